// File: doc/BRIEF.md
# Write-Completion Poller

This block sits on the host side of a byte-wide parallel nonvolatile memory. After the host has loaded a page and the memory has started its internal write cycle, a single start pulse hands control to the poller. The poller then reads the last loaded location repeatedly until the memory reports that the cycle is over. The host keeps the address bus on that location for the whole run. The poller drives the chip-enable and output-enable strobes itself. It holds them low for a programmable number of clock cycles before it samples the data bus.

Two status methods are supported. In inverted-data mode, bit 7 of the read data is compared against bit 7 of the byte that was written. In toggle mode, bit 6 of consecutive reads is compared. The memory finishes its cycle asynchronously to the host, so one read can land on the transition and show a status that says "finished" next to data that does not match. Such a result is never accepted on its own. The poller reads the location twice more and decides on those two reads.

Each run ends with exactly one of three results: done, fail or timeout. Each result is a one-cycle pulse, and the poller is idle again on the same cycle. The number of status reads allowed per run is programmable. The nominal 5 ms cycle time sets the scale for that limit.

Top module: `wr_done_poller`

## Requirements
- R1: During and after reset, with no run in progress, ce_n_o and oe_n_o are high and busy_o, done_o, fail_o and timeout_o are low.
- R2: A start_i pulse while idle begins a run. At that point it latches mode_i (0 = inverted-data, 1 = toggle), exp_data_i, access_cycles_i and max_polls_i. A start_i pulse while busy_o is high has no effect on the run in progress.
- R3: Every read drives ce_n_o and oe_n_o low together for exactly max(access_cycles_i, 1) consecutive cycles. The data bus is sampled on the last of those cycles, and the strobes are high for at least one cycle between reads.
- R4: In inverted-data mode, a status read whose bit 7 differs from bit 7 of the expected byte means the write is still in progress, and another status read follows. A status read whose whole byte equals the expected byte ends the run with done.
- R5: In toggle mode, the first status read of a run only sets the reference and counts as in progress. A later status read whose bit 6 differs from bit 6 of the previous status read means the write is still in progress. A later status read whose bit 6 matches the previous one and whose whole byte equals the expected byte ends the run with done.
- R6: If a status read indicates completion but the whole byte differs from the expected byte, the poller performs exactly two more reads of the location. If both reads equal the expected byte, the run ends with done.
- R7: If either of those two confirming reads differs from the expected byte, the run ends with fail, and only after the second confirming read.
- R8: Status reads are counted from the start of the run. When status read number max(max_polls_i, 1) still indicates "in progress", the run ends with timeout.
- R9: done_o, fail_o and timeout_o are single-cycle pulses, at most one per run and never two at once. busy_o is already low in the cycle of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (pulse, honoured only when idle) |
| mode_i | input | 1 | 0 = inverted-data status, 1 = toggle status |
| exp_data_i | input | 8 | True value of the last loaded byte |
| access_cycles_i | input | 8 | Strobe-low cycles per read (0 treated as 1) |
| max_polls_i | input | 16 | Status-read budget per run (0 treated as 1) |
| rd_data_i | input | 8 | Memory data bus |
| ce_n_o | output | 1 | Chip enable to memory, active low |
| oe_n_o | output | 1 | Output enable to memory, active low |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Write complete (pulse) |
| fail_o | output | 1 | Confirmed data mismatch (pulse) |
| timeout_o | output | 1 | Read budget exhausted (pulse) |

## Verification
The hardest case to reach is a read that lands on the completion instant. Its status bits say "finished" but its data does not match, and the two reads after it must then settle the verdict either way. The bench acts as the memory. It serves a scripted byte for each read, counting reads by the rising edge of the output enable. A script can therefore place one such transitional byte at an exact read position, followed by good or bad bytes. The same scripting produces toggle sequences that never settle, which drives the read budget to its limit, and a late start pulse is injected after the first read to show that it is ignored.

// File: rtl/poll_pkg.sv
package poll_pkg;

  typedef enum logic [1:0] {
    V_BUSY    = 2'd0,
    V_DONE    = 2'd1,
    V_SUSPECT = 2'd2
  } verdict_e;

  typedef enum logic {
    MODE_INV = 1'b0,
    MODE_TOG = 1'b1
  } poll_mode_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_STATUS = 2'd1,
    S_CONF1  = 2'd2,
    S_CONF2  = 2'd3
  } ctrl_state_e;

  typedef enum logic [1:0] {
    R_IDLE   = 2'd0,
    R_STROBE = 2'd1,
    R_GAP    = 2'd2
  } rd_state_e;

endpackage

// File: rtl/poll_reader.sv
module poll_reader
  import poll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              strobe_n_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              idle_o
);

  rd_state_e         state_q;
  logic [ACC_W-1:0]  cnt_q;
  logic [ACC_W-1:0]  acc_eff;
  logic              strobe_n_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign acc_eff = (acc_i == '0) ? ACC_W'(1) : acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= R_IDLE;
      cnt_q      <= '0;
      strobe_n_q <= 1'b1;
      valid_q    <= 1'b0;
      data_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      case (state_q)
        R_IDLE: begin
          if (req_i) begin
            state_q    <= R_STROBE;
            cnt_q      <= ACC_W'(1);
            strobe_n_q <= 1'b0;
          end
        end
        R_STROBE: begin
          if (cnt_q >= acc_eff) begin
            data_q     <= bus_i;
            valid_q    <= 1'b1;
            strobe_n_q <= 1'b1;
            state_q    <= R_GAP;
          end else begin
            cnt_q <= cnt_q + ACC_W'(1);
          end
        end
        R_GAP:   state_q <= R_IDLE;
        default: state_q <= R_IDLE;
      endcase
    end
  end

  assign strobe_n_o = strobe_n_q;
  assign valid_o    = valid_q;
  assign data_o     = data_q;
  assign idle_o     = (state_q == R_IDLE);

  // R3: a result only follows a strobe that was active
  p_valid_after_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(!strobe_n_q));

  // R3: strobes always released for a cycle after sampling
  p_gap_after_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> strobe_n_q);

endmodule

// File: rtl/poll_judge.sv
module poll_judge
  import poll_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INV_BIT = 7,
  parameter int TOG_BIT = 6
) (
  input  poll_mode_e        mode_i,
  input  logic              have_ref_i,
  input  logic              prev_tog_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] exp_i,
  output verdict_e          verdict_o
);

  logic status_ok;

  always_comb begin
    if (mode_i == MODE_TOG) status_ok = have_ref_i && (data_i[TOG_BIT] == prev_tog_i);
    else                    status_ok = (data_i[INV_BIT] == exp_i[INV_BIT]);
  end

  always_comb begin
    if (!status_ok)          verdict_o = V_BUSY;
    else if (data_i == exp_i) verdict_o = V_DONE;
    else                      verdict_o = V_SUSPECT;
  end

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import poll_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 8,
  parameter int CNT_W   = 16,
  parameter int INV_BIT = 7,
  parameter int TOG_BIT = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [ACC_W-1:0]  access_cycles_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_req_o,
  output logic [ACC_W-1:0]  acc_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o
);

  ctrl_state_e       state_q;
  poll_mode_e        mode_q;
  logic [DATA_W-1:0] exp_q;
  logic [ACC_W-1:0]  acc_q;
  logic [CNT_W-1:0]  max_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  max_eff;
  logic              have_ref_q;
  logic              prev_tog_q;
  logic              conf_ok_q;
  logic              req_q;
  logic              done_q;
  logic              fail_q;
  logic              to_q;
  logic              rd_match;
  verdict_e          verdict;

  poll_judge #(
    .DATA_W (DATA_W),
    .INV_BIT(INV_BIT),
    .TOG_BIT(TOG_BIT)
  ) u_judge (
    .mode_i    (mode_q),
    .have_ref_i(have_ref_q),
    .prev_tog_i(prev_tog_q),
    .data_i    (rd_data_i),
    .exp_i     (exp_q),
    .verdict_o (verdict)
  );

  assign cnt_nxt  = cnt_q + CNT_W'(1);
  assign max_eff  = (max_q == '0) ? CNT_W'(1) : max_q;
  assign rd_match = (rd_data_i == exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mode_q     <= MODE_INV;
      exp_q      <= '0;
      acc_q      <= '0;
      max_q      <= '0;
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      prev_tog_q <= 1'b0;
      conf_ok_q  <= 1'b0;
      req_q      <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      to_q       <= 1'b0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      to_q   <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            mode_q     <= poll_mode_e'(mode_i);
            exp_q      <= exp_data_i;
            acc_q      <= access_cycles_i;
            max_q      <= max_polls_i;
            cnt_q      <= '0;
            have_ref_q <= 1'b0;
            req_q      <= 1'b1;
            state_q    <= S_STATUS;
          end
        end
        S_STATUS: begin
          if (rd_valid_i) begin
            cnt_q      <= cnt_nxt;
            have_ref_q <= 1'b1;
            prev_tog_q <= rd_data_i[TOG_BIT];
            case (verdict)
              V_DONE: begin
                done_q  <= 1'b1;
                state_q <= S_IDLE;
              end
              V_SUSPECT: begin
                conf_ok_q <= 1'b1;
                req_q     <= 1'b1;
                state_q   <= S_CONF1;
              end
              default: begin
                if (cnt_nxt >= max_eff) begin
                  to_q    <= 1'b1;
                  state_q <= S_IDLE;
                end else begin
                  req_q <= 1'b1;
                end
              end
            endcase
          end
        end
        S_CONF1: begin
          if (rd_valid_i) begin
            conf_ok_q <= rd_match;
            req_q     <= 1'b1;
            state_q   <= S_CONF2;
          end
        end
        S_CONF2: begin
          if (rd_valid_i) begin
            if (conf_ok_q && rd_match) done_q <= 1'b1;
            else                       fail_q <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req_o  = req_q;
  assign acc_o     = acc_q;
  assign busy_o    = (state_q != S_IDLE);
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign timeout_o = to_q;

  p_one_result_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_q, fail_q, to_q}));

  p_result_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || fail_q || to_q) |=> !(done_q || fail_q || to_q));

  p_result_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q || fail_q || to_q) |-> (state_q == S_IDLE));

  p_fail_after_confirm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |-> $past(state_q == S_CONF2));

  p_timeout_budget_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> (cnt_q != '0) && (cnt_q >= max_q));

  p_start_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) |=> $stable(exp_q) && $stable(mode_q) && $stable(max_q));

endmodule

// File: rtl/wr_done_poller.sv
module wr_done_poller
  import poll_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 8,
  parameter int CNT_W   = 16,
  parameter int INV_BIT = DATA_W - 1,
  parameter int TOG_BIT = DATA_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [ACC_W-1:0]  access_cycles_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              ce_n_o,
  output logic              oe_n_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              timeout_o
);

  logic              rd_req;
  logic [ACC_W-1:0]  rd_acc;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              rd_idle;
  logic              strobe_n;

  poll_ctrl #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W),
    .CNT_W  (CNT_W),
    .INV_BIT(INV_BIT),
    .TOG_BIT(TOG_BIT)
  ) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .mode_i         (mode_i),
    .exp_data_i     (exp_data_i),
    .access_cycles_i(access_cycles_i),
    .max_polls_i    (max_polls_i),
    .rd_valid_i     (rd_valid),
    .rd_data_i      (rd_data),
    .rd_req_o       (rd_req),
    .acc_o          (rd_acc),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .fail_o         (fail_o),
    .timeout_o      (timeout_o)
  );

  poll_reader #(
    .DATA_W(DATA_W),
    .ACC_W (ACC_W)
  ) u_reader (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (rd_req),
    .acc_i     (rd_acc),
    .bus_i     (rd_data_i),
    .strobe_n_o(strobe_n),
    .valid_o   (rd_valid),
    .data_o    (rd_data),
    .idle_o    (rd_idle)
  );

  assign ce_n_o = strobe_n;
  assign oe_n_o = strobe_n;

  // R3: controller never asks for a read the reader cannot take
  p_req_when_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |-> rd_idle);

  // R1: memory left untouched whenever no run is active
  p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ce_n_o && oe_n_o));

endmodule

// File: tb/wr_done_poller_test.sv
module wr_done_poller_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [7:0]  exp_data = 8'h00;
  logic [7:0]  acc = 8'd1;
  logic [15:0] max_polls = 16'd1;
  logic [7:0]  rd_data;
  logic        ce_n, oe_n, busy, done, fail, tmo;

  int total = 0;
  int bad   = 0;

  logic [7:0] script [8];
  int reads = 0;
  int low_run = 0;
  int exp_len = 1;
  int len_err = 0;
  int pulse_cyc = 0;
  int pulse_err = 0;
  int got = -1;

  always #2 clk = ~clk;

  wr_done_poller uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .start_i        (start),
    .mode_i         (mode),
    .exp_data_i     (exp_data),
    .access_cycles_i(acc),
    .max_polls_i    (max_polls),
    .rd_data_i      (rd_data),
    .ce_n_o         (ce_n),
    .oe_n_o         (oe_n),
    .busy_o         (busy),
    .done_o         (done),
    .fail_o         (fail),
    .timeout_o      (tmo)
  );

  // memory model: serves script entry per completed read, last entry repeats
  always_comb rd_data = script[(reads > 7) ? 7 : reads];

  always @(negedge clk) begin
    if (ce_n != oe_n) len_err++;
    if (!oe_n) low_run++;
    else if (low_run > 0) begin
      reads++;
      if (low_run != exp_len) len_err++;
      low_run = 0;
    end
    if (done || fail || tmo) begin
      pulse_cyc++;
      if (busy) pulse_err++;
      if ((done + fail + tmo) > 1) pulse_err++;
      if (done) got = 0;
      if (fail) got = 1;
      if (tmo)  got = 2;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_case(input string req, input logic md, input logic [7:0] ex,
                          input logic [7:0] ac, input logic [15:0] mx,
                          input int n, input logic [7:0] s0, input logic [7:0] s1,
                          input logic [7:0] s2, input logic [7:0] s3,
                          input logic [7:0] s4, input logic [7:0] s5,
                          input int exp_out, input int exp_reads, input bit restart);
    logic [7:0] tmp [6];
    bit injected = 0;
    tmp[0] = s0; tmp[1] = s1; tmp[2] = s2; tmp[3] = s3; tmp[4] = s4; tmp[5] = s5;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) script[i] = (i < n) ? tmp[i] : tmp[n-1];
    reads = 0; low_run = 0; len_err = 0; pulse_cyc = 0; pulse_err = 0; got = -1;
    exp_len = (ac == 0) ? 1 : int'(ac);
    mode = md; exp_data = ex; acc = ac; max_polls = mx;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 5000 && got < 0; c++) begin
      @(posedge clk); #1;
      start = 1'b0;
      if (restart && !injected && reads >= 1 && busy) begin
        // would end at the next read if honoured (R2)
        start = 1'b1; exp_data = script[1]; mode = ~md; max_polls = 16'd1;
        injected = 1;
      end
    end
    start = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(got == exp_out, req, "outcome", got, exp_out);
    chk(reads == exp_reads, restart ? "R2" : req, "read count", reads, exp_reads);
    chk(len_err == 0, "R3", "strobe length errors", len_err, 0);
    chk(pulse_cyc == 1 && pulse_err == 0, "R9", "result pulse cycles", pulse_cyc, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) script[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    chk(ce_n && oe_n && !busy && !done && !fail && !tmo, "R1", "outputs in reset",
        {ce_n, oe_n, busy, done, fail, tmo}, 6'b110000);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk(ce_n && oe_n && !busy && !done && !fail && !tmo, "R1", "outputs after reset",
        {ce_n, oe_n, busy, done, fail, tmo}, 6'b110000);

    // R4 inverted: two busy reads then match; R2 late start ignored
    run_case("R4", 1'b0, 8'hA5, 8'd5, 16'd20, 3, 8'h25, 8'h25, 8'hA5, 8'h0, 8'h0, 8'h0, 0, 3, 1);
    // R4 boundary: complete on first read
    run_case("R4", 1'b0, 8'hA5, 8'd2, 16'd20, 1, 8'hA5, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 0, 1, 0);
    // R6 inverted: transitional read then two good rereads
    run_case("R6", 1'b0, 8'hA5, 8'd3, 16'd20, 4, 8'h25, 8'h80, 8'hA5, 8'hA5, 8'h0, 8'h0, 0, 4, 0);
    // R7 inverted: first reread bad, second good -> fail after both
    run_case("R7", 1'b0, 8'hA5, 8'd3, 16'd20, 3, 8'h80, 8'h81, 8'hA5, 8'h0, 8'h0, 8'h0, 1, 3, 0);
    // R5 toggle: alternating bit 6 then settles on true data
    run_case("R5", 1'b1, 8'h3C, 8'd1, 16'd20, 5, 8'h40, 8'h00, 8'h40, 8'h3C, 8'h3C, 8'h0, 0, 5, 0);
    // R6 toggle: settled bit 6 with wrong byte, rereads good; access 0 acts as 1
    run_case("R6", 1'b1, 8'h3C, 8'd0, 16'd20, 4, 8'h7C, 8'h40, 8'h3C, 8'h3C, 8'h0, 8'h0, 0, 4, 0);
    // R7 toggle: first reread good, second bad
    run_case("R7", 1'b1, 8'h3C, 8'd2, 16'd20, 4, 8'h00, 8'h00, 8'h3C, 8'h00, 8'h0, 8'h0, 1, 4, 0);
    // R8 toggle never settles, budget 3
    run_case("R8", 1'b1, 8'h3C, 8'd2, 16'd3, 6, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 2, 3, 0);
    // R8 budget 0 acts as 1
    run_case("R8", 1'b0, 8'h80, 8'd4, 16'd0, 1, 8'h00, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 2, 1, 0);

    #1;
    chk(ce_n && oe_n && !busy, "R1", "idle after runs", {ce_n, oe_n, busy}, 3'b110);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule